// File: doc/BRIEF.md
# Pretrigger Capture Buffer with Framed Byte Readout

This block records a window of 32-bit logic samples around a trigger event. After a start pulse it writes every qualified sample into a circular on-chip buffer. It ignores trigger pulses until the requested number of pretrigger samples has been collected. Once a trigger lands on a qualified sample, it stores enough further samples to complete the record, stops writing, and raises a ready status code.

Samples are qualified either by a plain enable, which is the internal timing mode, or by edges on one of two external clock channels, which is the state mode. The edge type and the channel come from an 8-bit mode code.

On a read request the stored record is sent out through a byte-wide valid/ready stream, oldest sample first. The stream opens with a start word and closes with an end marker. Zero filler bytes follow the marker until the byte total reaches a whole padding block. The buffer holds `2**ADDR_W` samples, which is a scaled-down stand-in for a much deeper external memory.

Top module: `cap_framer`

## Requirements
- R1: After reset `statusOut` is 0 and `outValid` is 0.
- R2: Modes 0x24 and 0x25 take a sample on a rising edge of `chanA` or `chanB` respectively. Modes 0x28 and 0x29 take one on a falling edge of A or B. Modes 0x26 and 0x27 take one on either edge of A or B. In these six modes `sampleEn` and the other channel have no effect. Any other mode value takes a sample in each cycle with `sampleEn` high.
- R3: A trigger counts only in a cycle that carries a qualified sample, and only after `pretrigIn` samples have been written since start. That sample becomes the trigger sample. Earlier triggers, and triggers in cycles without a sample, are ignored.
- R4: Counting the trigger sample, exactly `depthIn - pretrigIn` samples are stored from the trigger on. After that no sample or trigger changes the stored record.
- R5: `statusOut` reads 0 while a capture is unfinished. It reads 2 from the cycle after the clock edge that stores the final sample.
- R6: A start pulse returns `statusOut` to 0 on the next cycle, cancels any readout, and begins a new capture using the `depthIn` and `pretrigIn` values present in that cycle (1 <= depth <= 2**ADDR_W, pretrig < depth).
- R7: `readReq` starts a readout only while `statusOut` is 2. At any other time it is ignored.
- R8: The stream begins with the bytes 7F 02 1A 2B, which are the word 0x2B1A027F sent least significant byte first. These are followed by `depth` sample words, each sent least significant byte first. The first word is the sample taken `pretrig` samples before the trigger sample, and the words follow in capture order around the circular buffer.
- R9: The stream then sends 7F 03 3C 4D (the word 0x4D3C037F) followed by 0x00 bytes until the total is a multiple of PAD_BYTES (512). When the total already lands on that boundary, no filler is sent.
- R10: `outData` holds steady while `outValid` is high and `outReady` is low. `outValid` falls in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 32 | Sample word |
| sampleEn | input | 1 | Sample qualifier for internal mode |
| chanA | input | 1 | External clock channel A |
| chanB | input | 1 | External clock channel B |
| clkMode | input | 8 | Sampling mode code |
| trigIn | input | 1 | Trigger pulse |
| startIn | input | 1 | Start a new capture |
| depthIn | input | ADDR_W+1 | Record length in samples |
| pretrigIn | input | ADDR_W+1 | Samples kept ahead of the trigger |
| readReq | input | 1 | Begin readout |
| outReady | input | 1 | Stream sink ready |
| statusOut | output | 8 | 0 busy, 2 data ready |
| outData | output | 8 | Stream byte |
| outValid | output | 1 | Stream byte valid |

## Verification
A sample is stored at the clock edge of the cycle that qualifies it. The ready status appears one cycle after the final stored sample, and the bench reads it at the falling edge that follows each sample's stimulus. The first stream byte is valid one cycle after the read request. Each byte moves on the rising edge where both valid and ready are high. The bench changes `outReady` and samples `outData` at falling edges, so every byte is collected in the same half cycle in which it is offered.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam logic [31:0] HEAD_WORD = 32'h2B1A027F;
  localparam logic [31:0] TAIL_WORD = 32'h4D3C037F;

  localparam logic [7:0] STATUS_BUSY  = 8'd0;
  localparam logic [7:0] STATUS_READY = 8'd2;

  localparam logic [7:0] MODE_RISE_A = 8'h24;
  localparam logic [7:0] MODE_RISE_B = 8'h25;
  localparam logic [7:0] MODE_BOTH_A = 8'h26;
  localparam logic [7:0] MODE_BOTH_B = 8'h27;
  localparam logic [7:0] MODE_FALL_A = 8'h28;
  localparam logic [7:0] MODE_FALL_B = 8'h29;

  typedef enum logic [2:0] {
    CAP_IDLE, CAP_FILL, CAP_ARMED, CAP_POST, CAP_DONE
  } capState_e;

  typedef enum logic [2:0] {
    RD_IDLE, RD_HEAD, RD_DATA, RD_TAIL, RD_PAD
  } rdPhase_e;

  typedef struct packed {
    logic     wrEn;
    logic     clrWr;
    logic     markTrig;
    logic     rdLoad;
    logic     rdStep;
    rdPhase_e phase;
    logic [1:0] byteSel;
  } dpCtl_t;

endpackage

// File: rtl/cap_qualify.sv
module cap_qualify
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] clkMode,
  input  logic       sampleEn,
  input  logic       chanA,
  input  logic       chanB,
  output logic       sampleOk
);

  logic prevA, prevB;
  logic selCur, selPrev, edgeRise, edgeFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= chanA;
      prevB <= chanB;
    end
  end

  always_comb begin
    selCur   = clkMode[0] ? chanB : chanA;
    selPrev  = clkMode[0] ? prevB : prevA;
    edgeRise = selCur & ~selPrev;
    edgeFall = ~selCur & selPrev;
    case (clkMode)
      MODE_RISE_A, MODE_RISE_B: sampleOk = edgeRise;
      MODE_FALL_A, MODE_FALL_B: sampleOk = edgeFall;
      MODE_BOTH_A, MODE_BOTH_B: sampleOk = edgeRise | edgeFall;
      default:                  sampleOk = sampleEn;
    endcase
  end

  assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == MODE_RISE_A && sampleOk) |-> chanA);
  assert_fall_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == MODE_FALL_B && sampleOk) |-> !chanB);

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAD_BYTES = 512
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic            trigIn,
  input  logic            sampleOk,
  input  logic [ADDR_W:0] depthIn,
  input  logic [ADDR_W:0] pretrigIn,
  input  logic            readReq,
  input  logic            outReady,
  output dpCtl_t          ctl,
  output logic [ADDR_W:0] pretrigQ,
  output logic [7:0]      statusOut,
  output logic            outValid
);

  localparam int CW    = ADDR_W + 1;
  localparam int PAD_W = $clog2(PAD_BYTES);

  capState_e        capState;
  rdPhase_e         rdPhase;
  logic [CW-1:0]    depthQ, fillCnt, postLeft, wordLeft, postTotal;
  logic [1:0]       byteSel;
  logic [PAD_W-1:0] padCnt;
  logic             xfer, padWrap, liveCap;

  assign postTotal = depthQ - pretrigQ;
  assign outValid  = (rdPhase != RD_IDLE);
  assign xfer      = outValid && outReady;
  assign padWrap   = (padCnt == PAD_W'(PAD_BYTES - 1));
  assign liveCap   = (capState == CAP_FILL) || (capState == CAP_ARMED) ||
                     (capState == CAP_POST);
  assign statusOut = (capState == CAP_DONE) ? STATUS_READY : STATUS_BUSY;

  // capture sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capState <= CAP_IDLE;
      depthQ   <= '0;
      pretrigQ <= '0;
      fillCnt  <= '0;
      postLeft <= '0;
    end else if (startIn) begin
      depthQ   <= depthIn;
      pretrigQ <= pretrigIn;
      fillCnt  <= '0;
      capState <= (pretrigIn == '0) ? CAP_ARMED : CAP_FILL;
    end else begin
      case (capState)
        CAP_FILL: if (sampleOk) begin
          fillCnt <= fillCnt + CW'(1);
          if (fillCnt + CW'(1) == pretrigQ) capState <= CAP_ARMED;
        end
        CAP_ARMED: if (sampleOk && trigIn) begin
          if (postTotal == CW'(1)) begin
            capState <= CAP_DONE;
          end else begin
            capState <= CAP_POST;
            postLeft <= postTotal - CW'(1);
          end
        end
        CAP_POST: if (sampleOk) begin
          postLeft <= postLeft - CW'(1);
          if (postLeft == CW'(1)) capState <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  // readout sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPhase  <= RD_IDLE;
      byteSel  <= '0;
      padCnt   <= '0;
      wordLeft <= '0;
    end else if (startIn) begin
      rdPhase <= RD_IDLE;
    end else if (rdPhase == RD_IDLE) begin
      if (readReq && capState == CAP_DONE) begin
        rdPhase  <= RD_HEAD;
        byteSel  <= '0;
        padCnt   <= '0;
        wordLeft <= depthQ;
      end
    end else if (xfer) begin
      byteSel <= byteSel + 2'd1;
      padCnt  <= padCnt + PAD_W'(1);
      case (rdPhase)
        RD_HEAD: if (byteSel == 2'd3) rdPhase <= RD_DATA;
        RD_DATA: if (byteSel == 2'd3) begin
          wordLeft <= wordLeft - CW'(1);
          if (wordLeft == CW'(1)) rdPhase <= RD_TAIL;
        end
        RD_TAIL: if (byteSel == 2'd3) rdPhase <= padWrap ? RD_IDLE : RD_PAD;
        RD_PAD:  if (padWrap) rdPhase <= RD_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.clrWr    = startIn;
    ctl.wrEn     = !startIn && sampleOk && liveCap;
    ctl.markTrig = !startIn && capState == CAP_ARMED && sampleOk && trigIn;
    ctl.rdLoad   = !startIn && rdPhase == RD_IDLE && readReq && capState == CAP_DONE;
    ctl.rdStep   = !startIn && xfer && rdPhase == RD_DATA && byteSel == 2'd3;
    ctl.phase    = rdPhase;
    ctl.byteSel  = byteSel;
  end

  assert_trig_after_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.markTrig |-> (fillCnt == pretrigQ));
  assert_post_count_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    (capState == CAP_POST) |-> (postLeft != '0));
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (statusOut == STATUS_BUSY));

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [31:0]       sampleIn,
  input  logic [ADDR_W-1:0] pretrig,
  output logic [7:0]        outData
);

  localparam int SLOTS = 1 << ADDR_W;

  logic [31:0]       mem [SLOTS];
  logic [ADDR_W-1:0] wrPtr, trigAddr, rdPtr;
  logic [31:0]       selWord;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrPtr] <= sampleIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      trigAddr <= '0;
      rdPtr    <= '0;
    end else begin
      if (ctl.clrWr)     wrPtr <= '0;
      else if (ctl.wrEn) wrPtr <= wrPtr + ADDR_W'(1);
      if (ctl.markTrig)  trigAddr <= wrPtr;
      if (ctl.rdLoad)    rdPtr <= trigAddr - pretrig;
      else if (ctl.rdStep) rdPtr <= rdPtr + ADDR_W'(1);
    end
  end

  always_comb begin
    case (ctl.phase)
      RD_HEAD: selWord = HEAD_WORD;
      RD_DATA: selWord = mem[rdPtr];
      RD_TAIL: selWord = TAIL_WORD;
      default: selWord = '0;
    endcase
    outData = selWord[{ctl.byteSel, 3'b000} +: 8];
  end

  assert_no_write_in_readout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.phase != RD_IDLE) |-> !ctl.wrEn);

endmodule

// File: rtl/cap_framer.sv
module cap_framer
  import cap_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PAD_BYTES = 512
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     sampleIn,
  input  logic            sampleEn,
  input  logic            chanA,
  input  logic            chanB,
  input  logic [7:0]      clkMode,
  input  logic            trigIn,
  input  logic            startIn,
  input  logic [ADDR_W:0] depthIn,
  input  logic [ADDR_W:0] pretrigIn,
  input  logic            readReq,
  input  logic            outReady,
  output logic [7:0]      statusOut,
  output logic [7:0]      outData,
  output logic            outValid
);

  logic            sampleOk;
  dpCtl_t          ctl;
  logic [ADDR_W:0] pretrigQ;

  cap_qualify u_qual (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .sampleEn(sampleEn),
    .chanA(chanA), .chanB(chanB), .sampleOk(sampleOk)
  );

  cap_ctrl #(.ADDR_W(ADDR_W), .PAD_BYTES(PAD_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .trigIn(trigIn),
    .sampleOk(sampleOk), .depthIn(depthIn), .pretrigIn(pretrigIn),
    .readReq(readReq), .outReady(outReady), .ctl(ctl), .pretrigQ(pretrigQ),
    .statusOut(statusOut), .outValid(outValid)
  );

  cap_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .pretrig(pretrigQ[ADDR_W-1:0]), .outData(outData)
  );

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !startIn) |=> (outValid && $stable(outData)));
  assert_read_needs_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(statusOut) == STATUS_READY));
  assert_status_codes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == STATUS_BUSY) || (statusOut == STATUS_READY));

endmodule

// File: tb/sim_cap_framer.sv
module sim_cap_framer;

  localparam int AW = 7;
  localparam int PB = 512;
  localparam logic [31:0] HEADW = 32'h2B1A027F;
  localparam logic [31:0] TAILW = 32'h4D3C037F;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [31:0] sampleIn = '0;
  logic        sampleEn = 1'b0, chanA = 1'b0, chanB = 1'b0;
  logic [7:0]  clkMode = '0;
  logic        trigIn = 1'b0, startIn = 1'b0, readReq = 1'b0, outReady = 1'b0;
  logic [AW:0] depthIn = '0, pretrigIn = '0;
  logic [7:0]  statusOut, outData;
  logic        outValid;

  cap_framer #(.ADDR_W(AW), .PAD_BYTES(PB)) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleEn(sampleEn),
    .chanA(chanA), .chanB(chanB), .clkMode(clkMode), .trigIn(trigIn),
    .startIn(startIn), .depthIn(depthIn), .pretrigIn(pretrigIn),
    .readReq(readReq), .outReady(outReady), .statusOut(statusOut),
    .outData(outData), .outValid(outValid)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit doneRun = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  depth;
    logic [7:0]  pre;
    logic [7:0]  tE;
    logic [15:0] tL;
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h22, 8'd16,  8'd4,   8'd1,  16'd6,   32'h1000_0000},
    '{8'h00, 8'd128, 8'd100, 8'd50, 16'd100, 32'hA5A5_0000},
    '{8'h24, 8'd20,  8'd0,   8'd0,  16'd9,   32'h2222_0001},
    '{8'h25, 8'd12,  8'd11,  8'd2,  16'd40,  32'h3333_0002},
    '{8'h28, 8'd8,   8'd3,   8'd3,  16'd9,   32'h4444_0003},
    '{8'h29, 8'd10,  8'd2,   8'd0,  16'd5,   32'h5555_0004},
    '{8'h26, 8'd126, 8'd5,   8'd4,  16'd70,  32'h6666_0005},
    '{8'h27, 8'd32,  8'd16,  8'd10, 16'd200, 32'h7777_0006}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] val(logic [31:0] seed, int i);
    return seed + 32'(i) * 32'h01000193;
  endfunction

  function automatic bit isExt(logic [7:0] m);
    return (m >= 8'h24) && (m <= 8'h29);
  endfunction

  // one clock: the unused channel toggles every cycle (R2: must have no effect)
  task automatic tick(bit selB);
    if (selB) chanA = ~chanA; else chanB = ~chanB;
    @(negedge clk);
  endtask

  task automatic setSel(bit selB, logic v);
    if (selB) chanB = v; else chanA = v;
  endtask

  task automatic putSample(logic [7:0] m, logic [31:0] v, bit trg, int idx);
    bit selB;
    selB = m[0];
    if (isExt(m)) begin
      sampleEn = 1'b1;               // ignored in external modes (R2)
      if (m == 8'h24 || m == 8'h25) begin
        setSel(selB, 1'b1); sampleIn = v;  trigIn = trg;  tick(selB);
        setSel(selB, 1'b0); sampleIn = ~v; trigIn = 1'b0; tick(selB);
      end else if (m == 8'h28 || m == 8'h29) begin
        setSel(selB, 1'b1); sampleIn = ~v; trigIn = 1'b0; tick(selB);
        setSel(selB, 1'b0); sampleIn = v;  trigIn = trg;  tick(selB);
      end else begin
        setSel(selB, selB ? ~chanB : ~chanA);
        sampleIn = v; trigIn = trg; tick(selB);
      end
      trigIn = 1'b0;
    end else begin
      sampleEn = 1'b1; sampleIn = v; trigIn = trg; tick(1'b0);
      sampleEn = 1'b0; trigIn = 1'b0;
      if (idx % 3 == 2) begin
        // trigger without a qualified sample must be ignored (R3)
        sampleIn = ~v; trigIn = 1'b1; tick(1'b0);
        trigIn = 1'b0;
      end
    end
  endtask

  task automatic startCap(logic [7:0] m, int d, int p);
    clkMode = m; depthIn = (AW+1)'(d); pretrigIn = (AW+1)'(p);
    chanA = 1'b0; chanB = 1'b0; sampleEn = 1'b0; trigIn = 1'b0;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic runVector(vec_t v);
    int d, p, tEv, tLv, T, n, total, cnt, guard, bad8, bad9, noValid, statusBad;
    logic [31:0] a8, e8, a9, e9;
    logic [7:0] e;
    d = int'(v.depth); p = int'(v.pre); tEv = int'(v.tE); tLv = int'(v.tL);
    T = (tEv >= p) ? tEv : tLv;
    n = T - p + d;
    total = ((8 + 4*d + PB - 1) / PB) * PB;
    startCap(v.mode, d, p);
    statusBad = 0;
    for (int i = 0; i < n; i++) begin
      putSample(v.mode, val(v.seed, i), (i == tEv) || (i == tLv), i);
      if (i < n-1 && statusOut != 8'd0) statusBad++;
    end
    chk(statusBad == 0, "R5", "status busy during capture", 32'(statusBad), 0);
    chk(statusOut == 8'd2, "R5", "status ready after final sample", 32'(statusOut), 2);
    // R4: more samples and triggers after completion change nothing
    putSample(v.mode, 32'hDEAD_0000, 1'b1, n);
    putSample(v.mode, 32'hDEAD_0001, 1'b1, n+1);
    chk(statusOut == 8'd2, "R4", "status after extra samples", 32'(statusOut), 2);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    cnt = 0; guard = 0; bad8 = 0; bad9 = 0; noValid = 0;
    a8 = 0; e8 = 0; a9 = 0; e9 = 0;
    while (cnt < total && guard < 4000) begin
      outReady = (guard % 3) != 1;
      if (outValid && outReady) begin
        if (cnt < 4) e = HEADW[8*cnt +: 8];
        else if (cnt < 4 + 4*d) e = val(v.seed, T - p + (cnt-4)/4)[8*((cnt-4)%4) +: 8];
        else if (cnt < 8 + 4*d) e = TAILW[8*(cnt-4-4*d) +: 8];
        else e = 8'h00;
        if (outData != e) begin
          if (cnt < 4 + 4*d) begin
            if (bad8 == 0) begin a8 = 32'(outData); e8 = 32'(e); end
            bad8++;
          end else begin
            if (bad9 == 0) begin a9 = 32'(outData); e9 = 32'(e); end
            bad9++;
          end
        end
        cnt++;
      end else if (!outValid) noValid++;
      @(negedge clk);
      guard++;
    end
    outReady = 1'b0;
    // R2 R3 R8: sample qualification, trigger placement and record order
    chk(bad8 == 0, "R8", "header/record byte", a8, e8);
    chk(bad9 == 0, "R9", "end marker/filler byte", a9, e9);
    chk(cnt == total, "R9", "stream byte count", 32'(cnt), 32'(total));
    chk(noValid == 0, "R10", "valid gaps inside stream", 32'(noValid), 0);
    chk(!outValid, "R10", "valid after last byte", 32'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(statusOut == 8'd0, "R1", "status after reset", 32'(statusOut), 0);
    chk(!outValid, "R1", "valid after reset", 32'(outValid), 0);

    // table-driven captures and readouts
    for (int k = 0; k < NV; k++) runVector(VECS[k]);

    // R7: read request while capture unfinished
    startCap(8'h00, 4, 1);
    putSample(8'h00, 32'h0BAD_0000, 1'b0, 0);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    @(negedge clk);
    chk(!outValid, "R7", "read request during capture", 32'(outValid), 0);
    putSample(8'h00, 32'h0BAD_0001, 1'b1, 1);
    putSample(8'h00, 32'h0BAD_0002, 1'b0, 3);
    putSample(8'h00, 32'h0BAD_0003, 1'b0, 4);
    chk(statusOut == 8'd2, "R5", "short capture done", 32'(statusOut), 2);

    // R6: start clears ready status, then a read request is refused
    startCap(8'h00, 4, 1);
    chk(statusOut == 8'd0, "R6", "status after restart", 32'(statusOut), 0);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    @(negedge clk);
    chk(!outValid, "R7", "read request after restart", 32'(outValid), 0);

    doneRun = 1;
    summary();
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!doneRun) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: cycles=%0d expected < %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

endmodule